// File: doc/BRIEF.md
# ASCII Register Request Encoder

This block sits on the bus-master side of a serial debug link. It accepts register read and write commands over a valid/ready handshake. Each command carries a 16-bit address, 16-bit write data and a direction flag. The block turns each command into a fixed-length text request of uppercase hexadecimal characters and emits the request one byte per handshake on a byte-stream output. That output is meant to drive a UART transmitter.

The remote side answers every read with a reply of the same length as the request, and it has only a limited reply buffer. To protect that buffer, the encoder groups reads into chunks of at most `CHUNK_REQS` requests. It tracks how many reply bytes are still owed using a one-cycle strobe that pulses once per returned byte. A new chunk of reads cannot begin until that debt has been paid in full. Writes produce no reply, so they are never held back.

A watchdog raises a sticky flag when the owed-byte total stays unchanged for too long. A synchronous clear input drops the flag.

Top module: `ascii_req_encoder`

## Requirements
- R1: After reset `out_valid`, `chunk_busy` and `resp_timeout` are 0, and `cmd_ready` is 1 for a write command.
- R2: A read command produces exactly seven bytes: 0x52, four address digits, then 0x0D and 0x0A.
- R3: A write command produces exactly eleven bytes: 0x57, four address digits, four data digits, then 0x0D and 0x0A.
- R4: Hex digits are sent most significant nibble first. Nibble values 0 to 9 become 0x30 to 0x39, and values 10 to 15 become 0x41 to 0x46.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_byte` and `out_valid` hold their values.
- R6: `cmd_ready` is 1 only when no frame is in flight, or when the final 0x0A byte is being handed over in that cycle. Mid-frame it is 0.
- R7: Each accepted read adds seven to the owed-byte total. Each `resp_strobe` cycle subtracts one. `chunk_busy` is 1 exactly while the total is non-zero.
- R8: Once `CHUNK_REQS` reads have been accepted since the total was last zero, further reads see `cmd_ready` at 0 until the total returns to zero.
- R9: Writes are accepted even while reads are held back, and they add nothing to the owed-byte total.
- R10: A `resp_strobe` while the total is zero has no effect. It is not banked against later reads.
- R11: `resp_timeout` is set after `TIMEOUT_CYC` consecutive cycles in which the total is non-zero and no strobe arrives. Once set, it stays set.
- R12: `timeout_clr` clears `resp_timeout` at the next edge and takes priority over setting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when also valid |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | ADDR_W | Register address |
| cmd_data | input | DATA_W | Write data (unused for reads) |
| out_byte | output | 8 | Current request character |
| out_valid | output | 1 | Character available |
| out_ready | input | 1 | Downstream takes the character |
| resp_strobe | input | 1 | One reply byte has come back |
| chunk_busy | output | 1 | Reply bytes still owed |
| resp_timeout | output | 1 | Sticky flag: replies stalled |
| timeout_clr | input | 1 | Synchronous clear of `resp_timeout` |

## Verification
The frame encoder is driven with a table of reads and writes. The table's addresses and data mix all-zero, all-F, and mixed-digit values, which separates the decimal-digit mapping from the letter mapping and shows any nibble-order swap. A frame held off by `out_ready` shows whether the output is stable under back-pressure. Probing `cmd_ready` on every byte separates mid-frame refusal from the hand-over on the final byte.

The pacing logic is probed in four ways:
- Strobes that leave the owed total one short of zero.
- Strobes sent while nothing is owed.
- A full chunk with a write slipped in.
- A long silence, which exercises the sticky timeout and its clear.

// File: rtl/req_enc_pkg.sv
package req_enc_pkg;
   localparam logic [7:0] CH_READ  = 8'h52;
   localparam logic [7:0] CH_WRITE = 8'h57;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   // nibble to uppercase hex character
   function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
      if (n < 4'd10) return 8'h30 + {4'h0, n};
      else           return 8'h37 + {4'h0, n};
   endfunction
endpackage

// File: rtl/req_frame_seq.sv
module req_frame_seq
   import req_enc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          ld_write,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic          take,
   output logic          busy,
   output logic          last,
   output logic [7:0]    byte_o
);
   localparam int AN     = AW / 4;
   localparam int DN     = DW / 4;
   localparam int RD_LEN = AN + 3;
   localparam int WR_LEN = AN + DN + 3;
   localparam int IW     = $clog2(WR_LEN);

   logic [IW-1:0] idx;
   logic          f_write;
   logic [AW-1:0] f_addr;
   logic [DW-1:0] f_data;
   logic [AW-1:0] a_sh;
   logic [DW-1:0] d_sh;
   int            pos;
   int            flen;

   assign last = busy && (idx == (f_write ? IW'(WR_LEN - 1) : IW'(RD_LEN - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         idx     <= '0;
         f_write <= 1'b0;
         f_addr  <= '0;
         f_data  <= '0;
      end else if (load) begin
         busy    <= 1'b1;
         idx     <= '0;
         f_write <= ld_write;
         f_addr  <= ld_addr;
         f_data  <= ld_data;
      end else if (take) begin
         if (last) busy <= 1'b0;
         else      idx  <= idx + 1'b1;
      end
   end

   always_comb begin
      pos    = int'(idx);
      flen   = f_write ? WR_LEN : RD_LEN;
      a_sh   = '0;
      d_sh   = '0;
      byte_o = CH_LF;
      if (pos == 0) begin
         byte_o = f_write ? CH_WRITE : CH_READ;
      end else if (pos <= AN) begin
         a_sh   = f_addr >> (4 * (AN - pos));
         byte_o = nib_to_ascii(a_sh[3:0]);
      end else if (f_write && pos <= AN + DN) begin
         d_sh   = f_data >> (4 * (AN + DN - pos));
         byte_o = nib_to_ascii(d_sh[3:0]);
      end else if (pos == flen - 2) begin
         byte_o = CH_CR;
      end
   end
endmodule

// File: rtl/req_read_pacer.sv
module req_read_pacer #(
   parameter int CHUNK  = 256,
   parameter int RD_LEN = 7
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_accept,
   input  logic                        resp_strobe,
   output logic                        read_ok,
   output logic                        owed,
   output logic                        paid,
   output logic [$clog2(CHUNK+1)-1:0]  rd_cnt
);
   localparam int CW = $clog2(CHUNK + 1);
   localparam int OW = $clog2(CHUNK * RD_LEN + 1);

   logic [OW-1:0] outst;

   assign owed    = (outst != '0);
   assign paid    = resp_strobe && owed;
   assign read_ok = (rd_cnt < CW'(CHUNK)) || !owed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst  <= '0;
         rd_cnt <= '0;
      end else begin
         outst  <= outst + (rd_accept ? OW'(RD_LEN) : '0) - (paid ? OW'(1) : '0);
         rd_cnt <= (owed ? rd_cnt : '0) + (rd_accept ? CW'(1) : '0);
      end
   end
endmodule

// File: rtl/req_resp_watchdog.sv
module req_resp_watchdog #(
   parameter int LIMIT = 1000000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic progress,
   input  logic clr,
   output logic flag
);
   localparam int TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt;
   logic          stalled;

   assign stalled = pending && !progress;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (!stalled)                cnt <= '0;
         else if (cnt != TW'(LIMIT))  cnt <= cnt + 1'b1;

         if (clr)                                       flag <= 1'b0;
         else if (stalled && cnt >= TW'(LIMIT - 1))     flag <= 1'b1;
      end
   end
endmodule

// File: rtl/ascii_req_encoder.sv
module ascii_req_encoder #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int CHUNK_REQS  = 256,
   parameter int TIMEOUT_CYC = 1000000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic [7:0]        out_byte,
   output logic              out_valid,
   input  logic              out_ready,
   input  logic              resp_strobe,
   output logic              chunk_busy,
   output logic              resp_timeout,
   input  logic              timeout_clr
);
   localparam int RD_LEN = ADDR_W / 4 + 3;
   localparam int CNT_W  = $clog2(CHUNK_REQS + 1);

   if (ADDR_W < 4 || ADDR_W % 4 != 0) begin : g_bad_addr_w
      $error("ADDR_W must be a positive multiple of 4");
   end
   if (DATA_W < 4 || DATA_W % 4 != 0) begin : g_bad_data_w
      $error("DATA_W must be a positive multiple of 4");
   end
   if (CHUNK_REQS < 1) begin : g_bad_chunk
      $error("CHUNK_REQS must be at least 1");
   end
   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be at least 1");
   end

   logic             seq_busy;
   logic             seq_last;
   logic             take;
   logic             accept;
   logic             read_ok;
   logic             paid;
   logic [CNT_W-1:0] rd_in_chunk;

   assign take      = out_valid && out_ready;
   assign cmd_ready = (!seq_busy || (take && seq_last)) && (cmd_write || read_ok);
   assign accept    = cmd_valid && cmd_ready;
   assign out_valid = seq_busy;

   req_frame_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .ld_write (cmd_write),
      .ld_addr  (cmd_addr),
      .ld_data  (cmd_data),
      .take     (take),
      .busy     (seq_busy),
      .last     (seq_last),
      .byte_o   (out_byte)
   );

   req_read_pacer #(.CHUNK(CHUNK_REQS), .RD_LEN(RD_LEN)) u_pacer (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_accept   (accept && !cmd_write),
      .resp_strobe (resp_strobe),
      .read_ok     (read_ok),
      .owed        (chunk_busy),
      .paid        (paid),
      .rd_cnt      (rd_in_chunk)
   );

   req_resp_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending  (chunk_busy),
      .progress (paid),
      .clr      (timeout_clr),
      .flag     (resp_timeout)
   );
endmodule

// File: rtl/ascii_req_encoder_chk.sv
module ascii_req_encoder_chk #(
   parameter int CHUNK_REQS = 256
)(
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cmd_valid,
   input logic                            cmd_ready,
   input logic                            cmd_write,
   input logic [7:0]                      out_byte,
   input logic                            out_valid,
   input logic                            out_ready,
   input logic                            chunk_busy,
   input logic                            resp_timeout,
   input logic                            timeout_clr,
   input logic [$clog2(CHUNK_REQS+1)-1:0] rd_cnt
);
   p_first_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> out_valid && (out_byte == 8'h52 || out_byte == 8'h57));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte));

   p_no_mid_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !cmd_ready);

   p_busy_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chunk_busy) |-> $past(cmd_valid && cmd_ready && !cmd_write));

   p_chunk_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_cnt) <= CHUNK_REQS);

   p_write_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && cmd_write |-> cmd_ready);

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_timeout && !timeout_clr |=> resp_timeout);

   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_clr |=> !resp_timeout);
endmodule

bind ascii_req_encoder ascii_req_encoder_chk #(.CHUNK_REQS(CHUNK_REQS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .cmd_write    (cmd_write),
   .out_byte     (out_byte),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .chunk_busy   (chunk_busy),
   .resp_timeout (resp_timeout),
   .timeout_clr  (timeout_clr),
   .rd_cnt       (rd_in_chunk)
);

// File: tb/ascii_req_encoder_tb.sv
module ascii_req_encoder_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CHUNK      = 2;
   localparam int TMO        = 100;
   localparam int NVEC       = 6;
   // {write, addr, data}
   localparam logic [32:0] VEC [NVEC] = '{
      {1'b0, 16'h1234, 16'h0000},
      {1'b1, 16'hABCD, 16'h5E6F},
      {1'b0, 16'hF0A9, 16'h0000},
      {1'b1, 16'h0000, 16'hFFFF},
      {1'b0, 16'hFFFF, 16'h0000},
      {1'b1, 16'h7B3C, 16'h0D0A}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_write = 1'b0;
   logic [15:0] cmd_addr = '0;
   logic [15:0] cmd_data = '0;
   logic [7:0]  out_byte;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        resp_strobe = 1'b0;
   logic        chunk_busy;
   logic        resp_timeout;
   logic        timeout_clr = 1'b0;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ascii_req_encoder #(.CHUNK_REQS(CHUNK), .TIMEOUT_CYC(TMO)) u_dut (
      .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_write, .cmd_addr, .cmd_data,
      .out_byte, .out_valid, .out_ready, .resp_strobe, .chunk_busy,
      .resp_timeout, .timeout_clr
   );

   function automatic logic [7:0] hexc(input logic [3:0] n);
      return (n < 10) ? 8'd48 + 8'(n) : 8'd65 + 8'(n) - 8'd10;
   endfunction

   function automatic logic [7:0] exp_byte(input logic w, input logic [15:0] a,
                                           input logic [15:0] d, input int i);
      int n = w ? 11 : 7;
      if (i == 0) return w ? "W" : "R";
      if (i < 5) return hexc(a[15-4*(i-1) -: 4]);
      if (w && i < 9) return hexc(d[15-4*(i-5) -: 4]);
      if (i == n - 2) return 8'h0D;
      return 8'h0A;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic w, input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_data = d;
      #1;
      while (!cmd_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      cmd_valid = 1'b0; cmd_write = 1'b0;
   endtask

   // starts where byte 0 may already be visible, ends at a negedge
   task automatic collect(input logic w, input logic [15:0] a, input logic [15:0] d,
                          input string req);
      int n = w ? 11 : 7;
      for (int i = 0; i < n; i++) begin
         while (!out_valid) @(negedge clk);
         check(req, {24'h0, out_byte}, {24'h0, exp_byte(w, a, d, i)});
         cmd_write = 1'b1; #1;
         check("R6 cmd_ready per byte", {31'h0, cmd_ready}, {31'h0, (i == n-1) && out_ready});
         cmd_write = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic resp(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); resp_strobe = 1'b1; end
      @(negedge clk); resp_strobe = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", {31'h0, out_valid}, 32'h0);
      check("R1 chunk_busy", {31'h0, chunk_busy}, 32'h0);
      check("R1 resp_timeout", {31'h0, resp_timeout}, 32'h0);
      cmd_write = 1'b1; #1;
      check("R1 cmd_ready", {31'h0, cmd_ready}, 32'h1);
      cmd_write = 1'b0;

      // table of frames: R2 reads, R3 writes, R4 digit mapping
      for (int v = 0; v < NVEC; v++) begin
         send(VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
         @(negedge clk);
         collect(VEC[v][32], VEC[v][31:16], VEC[v][15:0],
                 VEC[v][32] ? "R3 R4 write frame" : "R2 R4 read frame");
         if (!VEC[v][32]) resp(7);
         check(VEC[v][32] ? "R9 write owes nothing" : "R7 paid back",
               {31'h0, chunk_busy}, 32'h0);
      end

      // R5 back-pressure hold, R6 refusal mid-frame
      out_ready = 1'b0;
      send(1'b1, 16'h9C2E, 16'h4B1D);
      @(negedge clk);
      b0 = out_byte;
      cmd_valid = 1'b1; cmd_write = 1'b1; #1;
      check("R6 no accept while stalled", {31'h0, cmd_ready}, 32'h0);
      cmd_valid = 1'b0; cmd_write = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check("R5 byte held", {23'h0, out_valid, out_byte}, {23'h0, 1'b1, b0});
      end
      out_ready = 1'b1;
      collect(1'b1, 16'h9C2E, 16'h4B1D, "R5 R3 frame after stall");

      // R7 owed-byte count
      send(1'b0, 16'h1A2B, 16'h0);
      @(negedge clk);
      collect(1'b0, 16'h1A2B, 16'h0, "R2 read frame");
      check("R7 busy after read", {31'h0, chunk_busy}, 32'h1);
      resp(6);
      check("R7 one byte short", {31'h0, chunk_busy}, 32'h1);
      resp(1);
      check("R7 fully paid", {31'h0, chunk_busy}, 32'h0);

      // R10 strobes with nothing owed are ignored
      resp(5);
      check("R10 idle strobes", {31'h0, chunk_busy}, 32'h0);
      send(1'b0, 16'h00C0, 16'h0);
      @(negedge clk);
      collect(1'b0, 16'h00C0, 16'h0, "R2 read frame");
      resp(6);
      check("R10 not banked", {31'h0, chunk_busy}, 32'h1);
      resp(1);

      // R8 chunk limit, R9 writes pass
      send(1'b0, 16'h2222, 16'h0);
      @(negedge clk);
      collect(1'b0, 16'h2222, 16'h0, "R2 read frame");
      send(1'b0, 16'h3333, 16'h0);
      @(negedge clk);
      collect(1'b0, 16'h3333, 16'h0, "R2 read frame");
      cmd_valid = 1'b1; cmd_write = 1'b0; #1;
      check("R8 read held at chunk limit", {31'h0, cmd_ready}, 32'h0);
      cmd_write = 1'b1; #1;
      check("R9 write passes full chunk", {31'h0, cmd_ready}, 32'h1);
      cmd_valid = 1'b0; cmd_write = 1'b0;
      send(1'b1, 16'hBEEF, 16'hCAFE);
      @(negedge clk);
      collect(1'b1, 16'hBEEF, 16'hCAFE, "R9 R3 write frame");
      resp(13);
      cmd_valid = 1'b1; #1;
      check("R8 still held one short", {31'h0, cmd_ready}, 32'h0);
      cmd_valid = 1'b0;
      resp(1);
      cmd_valid = 1'b1; #1;
      check("R8 released when paid", {31'h0, cmd_ready}, 32'h1);
      cmd_valid = 1'b0;

      // R11 timeout sticky, R12 clear
      @(negedge clk); timeout_clr = 1'b1;
      @(negedge clk); timeout_clr = 1'b0;
      send(1'b0, 16'h0F0F, 16'h0);
      @(negedge clk);
      collect(1'b0, 16'h0F0F, 16'h0, "R2 read frame");
      repeat (50) @(negedge clk);
      check("R11 not yet", {31'h0, resp_timeout}, 32'h0);
      repeat (60) @(negedge clk);
      check("R11 raised", {31'h0, resp_timeout}, 32'h1);
      resp(7);
      check("R11 sticky", {31'h0, resp_timeout}, 32'h1);
      timeout_clr = 1'b1;
      @(negedge clk); timeout_clr = 1'b0;
      check("R12 cleared", {31'h0, resp_timeout}, 32'h0);
      repeat (10) @(negedge clk);
      check("R12 stays clear", {31'h0, resp_timeout}, 32'h0);

      finish_run();
   end
endmodule